// File: doc/BRIEF.md
# USB Host Transmit Endpoint Controller

This block runs one host-side transmit endpoint. It holds an 8-bit control and status register that software reads and writes through a plain register port. It keeps track of how many packets wait in a packet buffer of one or more slots, and it keeps the data-toggle bit. The block asks a protocol engine for a token whenever a packet is waiting and the endpoint is not halted. It tells the engine whether the token is SETUP or OUT, and which data toggle to use.

The engine reports the handshake outcome as a one-cycle pulse: ACK, NAK, STALL, or no handshake before the timeout. From these pulses the block drains packets and flips the toggle. It also retries transfers that got no handshake, counts consecutive NAKs against a programmable limit, halts on error conditions, raises a one-cycle endpoint interrupt pulse, and asks for any DMA transfer to stop when a STALL arrives. Software commands are written as ones into command bits. Status bits are cleared by writing zero to them.

Top module: `usb_htx_ep_ctrl`

## Requirements
- R1: After reset, reg_rdata is 0x00, and tok_req, tok_setup, tok_toggle, ep_int and dma_stop are all low.
- R2: Writing 1 to bit 0 (packet ready) queues one packet if a slot is free. Bit 1 reads 1 while any packet is queued. Bit 0 reads 1 only while every slot is occupied, so with two slots it clears itself after the first packet.
- R3: tok_req is high exactly when a packet is queued and none of bits 7, 5 and 2 is set. tok_setup follows bit 4 (token select), and tok_toggle follows the data toggle.
- R4: An ACK accepted while tok_req is high has four effects: the oldest packet is removed, bit 0 is cleared, the data toggle flips, and ep_int pulses for one cycle in the next cycle.
- R5: Writing 1 to bit 6 clears the data toggle. Writing 1 to bit 4 also clears it. Bit 6 always reads 0.
- R6: Writing 1 to bit 3 (flush) with bit 0 at 0 removes the newest packet, clears bit 0 and pulses ep_int. When bit 3 and bit 0 are written as 1 together, the packet being queued is cancelled instead. Two flushes empty a full two-slot buffer. Bit 3 always reads 0.
- R7: ep_type encodes 00 control, 01 isochronous, 10 bulk, 11 interrupt. For bulk and interrupt endpoints, the third accepted timeout without an intervening ACK or flush does four things: it sets bit 2, empties the buffer, clears bit 0 and pulses ep_int. Control and isochronous endpoints ignore timeouts.
- R8: A STALL accepted while tok_req is high does four things: it sets bit 5, empties the buffer, clears bit 0 and pulses dma_stop for exactly one cycle.
- R9: For a bulk endpoint with a non-zero nak_limit, bit 7 sets on the nak_limit-th consecutive accepted NAK, and the endpoint halts. A limit of 0, or any other endpoint type, never sets bit 7.
- R10: Writing 0 to bit 7, 5 or 2 clears that bit, and writing 1 leaves it unchanged. Clearing bit 7 restarts the NAK count. Clearing bit 2 restarts the timeout count. Writes to bit 1 are ignored.
- R11: Handshake pulses that arrive while tok_req is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| ep_type | input | 2 | Endpoint transfer type |
| nak_limit | input | NAK_W | Consecutive NAK limit, 0 disables |
| hs_ack | input | 1 | ACK received pulse |
| hs_nak | input | 1 | NAK received pulse |
| hs_stall | input | 1 | STALL received pulse |
| hs_timeout | input | 1 | No handshake received pulse |
| tok_req | output | 1 | Request a transaction from the engine |
| tok_setup | output | 1 | 1 = SETUP token, 0 = OUT token |
| tok_toggle | output | 1 | Data toggle for the next packet |
| ep_int | output | 1 | Endpoint interrupt pulse |
| dma_stop | output | 1 | Request to abort DMA |

## Verification
The buffer is filled one slot at a time and then to full. This separates the self-clearing ready bit from the ready bit that stays high while the buffer is full. Single flushes, back-to-back flushes and a combined flush-with-ready write show the difference between dropping the newest packet and cancelling a packet still being queued. Runs of timeouts and NAKs are applied under each endpoint type and several limits, including a run broken by an ACK, to check exactly where each counter trips or restarts. Handshakes sent while the endpoint is halted or empty show whether any state moves without a token request.

// File: rtl/htx_ep_pkg.sv
package htx_ep_pkg;
   localparam int B_RDY   = 0;
   localparam int B_NEMP  = 1;
   localparam int B_ERR   = 2;
   localparam int B_FLUSH = 3;
   localparam int B_SETUP = 4;
   localparam int B_STALL = 5;
   localparam int B_CLRT  = 6;
   localparam int B_NAKTO = 7;

   typedef enum logic [1:0] {
      EP_CTRL = 2'b00,
      EP_ISO  = 2'b01,
      EP_BULK = 2'b10,
      EP_INTR = 2'b11
   } ep_kind_e;
endpackage

// File: rtl/htx_fifo_track.sv
module htx_fifo_track #(
   parameter  int DEPTH = 2,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit,
   input  logic          drop_one,
   input  logic          drop_all,
   output logic [CW-1:0] count,
   output logic          full
);
   initial begin
      if (DEPTH < 1) $error("htx_fifo_track: DEPTH must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (drop_all)
         count <= '0;
      else if (commit && !drop_one && !full)
         count <= count + 1'b1;
      else if (drop_one && !commit && count != '0)
         count <= count - 1'b1;
   end

   assign full = (int'(count) == DEPTH);

   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count) <= DEPTH);
   p_drop_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
      drop_all |=> (count == '0));
endmodule

// File: rtl/htx_event_ctr.sv
module htx_event_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);
   initial begin
      if (W < 1) $error("htx_event_ctr: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         count <= '0;
      else if (inc && count != '1)
         count <= count + 1'b1;
   end

   p_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '1 && !clr) |=> (count == '1));
endmodule

// File: rtl/usb_htx_ep_ctrl.sv
module usb_htx_ep_ctrl
   import htx_ep_pkg::*;
#(
   parameter  int DEPTH      = 2,
   parameter  int MAX_TRIES  = 3,
   parameter  int NAK_W      = 8,
   parameter  bit HAS_NAK_TO = 1'b1,
   localparam int CW         = $clog2(DEPTH + 1),
   localparam int RTY_W      = $clog2(MAX_TRIES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic [1:0]       ep_type,
   input  logic [NAK_W-1:0] nak_limit,
   input  logic             hs_ack,
   input  logic             hs_nak,
   input  logic             hs_stall,
   input  logic             hs_timeout,
   output logic             tok_req,
   output logic             tok_setup,
   output logic             tok_toggle,
   output logic             ep_int,
   output logic             dma_stop
);
   initial begin
      if (MAX_TRIES < 1) $error("usb_htx_ep_ctrl: MAX_TRIES must be at least 1");
      if (NAK_W < 1)     $error("usb_htx_ep_ctrl: NAK_W must be at least 1");
   end

   logic             rdy_q, dt_q, setup_q, nakto_q, stalled_q, err_q;
   logic             rdy_n, dt_n, setup_n, nakto_n, stalled_n, err_n;
   logic             int_n, dma_n;
   logic             commit, drop_one, drop_all;
   logic             rty_clr, rty_inc, nak_clr, nak_inc;
   logic [CW-1:0]    pkt_cnt;
   logic             pkt_full;
   logic [RTY_W-1:0] rty_cnt;
   logic [NAK_W-1:0] nak_cnt;
   logic             halted, retry_kind, nak_kind;

   htx_fifo_track #(.DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .commit(commit), .drop_one(drop_one),
      .drop_all(drop_all), .count(pkt_cnt), .full(pkt_full)
   );

   htx_event_ctr #(.W(RTY_W)) u_retry (
      .clk(clk), .rst_n(rst_n), .clr(rty_clr), .inc(rty_inc), .count(rty_cnt)
   );

   generate
      if (HAS_NAK_TO) begin : g_nak
         htx_event_ctr #(.W(NAK_W)) u_nak (
            .clk(clk), .rst_n(rst_n), .clr(nak_clr), .inc(nak_inc), .count(nak_cnt)
         );
      end else begin : g_no_nak
         assign nak_cnt = '0;
      end
   endgenerate

   assign halted     = nakto_q | stalled_q | err_q;
   assign tok_req    = (pkt_cnt != '0) && !halted;
   assign retry_kind = (ep_type == EP_BULK) || (ep_type == EP_INTR);
   assign nak_kind   = HAS_NAK_TO && (ep_type == EP_BULK) && (nak_limit != '0);

   always_comb begin
      rdy_n     = rdy_q;
      dt_n      = dt_q;
      setup_n   = setup_q;
      nakto_n   = nakto_q;
      stalled_n = stalled_q;
      err_n     = err_q;
      int_n     = 1'b0;
      dma_n     = 1'b0;
      commit    = 1'b0;
      drop_one  = 1'b0;
      drop_all  = 1'b0;
      rty_clr   = 1'b0;
      rty_inc   = 1'b0;
      nak_clr   = 1'b0;
      nak_inc   = 1'b0;

      if (reg_wr) begin
         nakto_n   = nakto_q   & reg_wdata[B_NAKTO];
         stalled_n = stalled_q & reg_wdata[B_STALL];
         err_n     = err_q     & reg_wdata[B_ERR];
         nak_clr   = nakto_q & !reg_wdata[B_NAKTO];
         rty_clr   = err_q   & !reg_wdata[B_ERR];
         setup_n   = reg_wdata[B_SETUP];
         if (reg_wdata[B_CLRT] || reg_wdata[B_SETUP])
            dt_n = 1'b0;
         if (reg_wdata[B_FLUSH]) begin
            rdy_n    = 1'b0;
            int_n    = 1'b1;
            rty_clr  = 1'b1;
            nak_clr  = 1'b1;
            drop_one = !reg_wdata[B_RDY];
         end else if (reg_wdata[B_RDY] && !pkt_full) begin
            commit = 1'b1;
            rdy_n  = (int'(pkt_cnt) + 1 == DEPTH);
         end
      end

      if (tok_req) begin
         if (hs_stall) begin
            stalled_n = 1'b1;
            drop_all  = 1'b1;
            rdy_n     = 1'b0;
            dma_n     = 1'b1;
            rty_clr   = 1'b1;
            nak_clr   = 1'b1;
         end else if (hs_ack) begin
            drop_one = 1'b1;
            rdy_n    = 1'b0;
            dt_n     = ~dt_n;
            int_n    = 1'b1;
            rty_clr  = 1'b1;
            nak_clr  = 1'b1;
         end else if (hs_nak && nak_kind) begin
            nak_inc = 1'b1;
            if ({1'b0, nak_cnt} + 1'b1 >= {1'b0, nak_limit})
               nakto_n = 1'b1;
         end else if (hs_timeout && retry_kind) begin
            if (int'(rty_cnt) + 1 >= MAX_TRIES) begin
               err_n    = 1'b1;
               drop_all = 1'b1;
               rdy_n    = 1'b0;
               int_n    = 1'b1;
               rty_clr  = 1'b1;
            end else begin
               rty_inc = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q     <= 1'b0;
         dt_q      <= 1'b0;
         setup_q   <= 1'b0;
         nakto_q   <= 1'b0;
         stalled_q <= 1'b0;
         err_q     <= 1'b0;
         ep_int    <= 1'b0;
         dma_stop  <= 1'b0;
      end else begin
         rdy_q     <= rdy_n;
         dt_q      <= dt_n;
         setup_q   <= setup_n;
         nakto_q   <= nakto_n;
         stalled_q <= stalled_n;
         err_q     <= err_n;
         ep_int    <= int_n;
         dma_stop  <= dma_n;
      end
   end

   always_comb begin
      reg_rdata          = '0;
      reg_rdata[B_RDY]   = rdy_q;
      reg_rdata[B_NEMP]  = (pkt_cnt != '0);
      reg_rdata[B_ERR]   = err_q;
      reg_rdata[B_SETUP] = setup_q;
      reg_rdata[B_STALL] = stalled_q;
      reg_rdata[B_NAKTO] = nakto_q;
   end

   assign tok_setup  = setup_q;
   assign tok_toggle = dt_q;

   p_txrdy_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_q |-> pkt_full);
   p_ack_int_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_req && hs_ack) |=> ep_int);
   p_ack_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_req && hs_ack && !reg_wr) |=> (tok_toggle != $past(tok_toggle)));
   p_err_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> (pkt_cnt == '0));
   p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_req && hs_stall) |=> (dma_stop && stalled_q && !rdy_q));
   p_dma_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_stop |=> !dma_stop);
   p_idle_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!tok_req && !reg_wr) |=> $stable(reg_rdata));
endmodule

// File: tb/usb_htx_ep_ctrl_tb.sv
module usb_htx_ep_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 2;
   localparam int NAK_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [1:0] ep_type = 2'b10;
   logic [NAK_W-1:0] nak_limit = 8'd3;
   logic hs_ack = 0, hs_nak = 0, hs_stall = 0, hs_timeout = 0;
   logic tok_req, tok_setup, tok_toggle, ep_int, dma_stop;

   int vectors = 0;
   int errors = 0;
   string cur_req = "R1";

   usb_htx_ep_ctrl #(.DEPTH(DEPTH), .NAK_W(NAK_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .ep_type(ep_type), .nak_limit(nak_limit),
      .hs_ack(hs_ack), .hs_nak(hs_nak), .hs_stall(hs_stall),
      .hs_timeout(hs_timeout), .tok_req(tok_req), .tok_setup(tok_setup),
      .tok_toggle(tok_toggle), .ep_int(ep_int), .dma_stop(dma_stop)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference: a queue of packet tags plus plain status flags
   int pkts[$];
   int next_tag = 0;
   bit m_rdy, m_dt, m_setup, m_nakto, m_stall, m_err, m_int, m_dma;
   int m_tries, m_naks;

   function automatic bit m_req();
      return pkts.size() > 0 && !(m_nakto || m_stall || m_err);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         pkts.delete();
         {m_rdy, m_dt, m_setup, m_nakto, m_stall, m_err, m_int, m_dma} = '0;
         m_tries = 0; m_naks = 0;
      end else begin
         bit req;
         req = m_req();
         m_int = 0; m_dma = 0;
         if (reg_wr) begin
            if (m_nakto && !reg_wdata[7]) begin m_nakto = 0; m_naks = 0; end
            if (m_err && !reg_wdata[2]) begin m_err = 0; m_tries = 0; end
            if (!reg_wdata[5]) m_stall = 0;
            m_setup = reg_wdata[4];
            if (reg_wdata[4] || reg_wdata[6]) m_dt = 0;
            if (reg_wdata[3]) begin
               if (!reg_wdata[0] && pkts.size() > 0) void'(pkts.pop_back());
               m_rdy = 0; m_int = 1; m_tries = 0; m_naks = 0;
            end else if (reg_wdata[0] && pkts.size() < DEPTH) begin
               pkts.push_back(next_tag++);
               m_rdy = (pkts.size() == DEPTH);
            end
         end
         if (req) begin
            if (hs_stall) begin
               pkts.delete(); m_stall = 1; m_rdy = 0; m_dma = 1;
               m_tries = 0; m_naks = 0;
            end else if (hs_ack) begin
               if (pkts.size() > 0) void'(pkts.pop_front());
               m_rdy = 0; m_dt = !m_dt; m_int = 1; m_tries = 0; m_naks = 0;
            end else if (hs_nak) begin
               if (ep_type == 2'b10 && nak_limit != 0) begin
                  if (m_naks < 255) m_naks++;
                  if (m_naks >= nak_limit) m_nakto = 1;
               end
            end else if (hs_timeout) begin
               if (ep_type[1]) begin
                  m_tries++;
                  if (m_tries >= 3) begin
                     pkts.delete(); m_err = 1; m_rdy = 0; m_int = 1; m_tries = 0;
                  end
               end
            end
         end
      end
   end

   task automatic cmp(string tag, string what, int act, int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         logic [7:0] exp_rd;
         exp_rd = {m_nakto, 1'b0, m_stall, m_setup, 1'b0, m_err, pkts.size() > 0, m_rdy};
         cmp(cur_req, "rdata", reg_rdata, exp_rd);
         cmp(cur_req, "tok_req", tok_req, m_req());
         cmp(cur_req, "tok_setup", tok_setup, m_setup);
         cmp(cur_req, "tok_toggle", tok_toggle, m_dt);
         cmp(cur_req, "ep_int", ep_int, m_int);
         cmp(cur_req, "dma_stop", dma_stop, m_dma);
      end
   end

   task automatic wr(input logic [7:0] v);
      @(negedge clk); reg_wr = 1; reg_wdata = v;
      @(negedge clk); reg_wr = 0; reg_wdata = 0;
   endtask

   task automatic hs(input int kind);
      @(negedge clk);
      hs_ack = (kind == 0); hs_nak = (kind == 1);
      hs_stall = (kind == 2); hs_timeout = (kind == 3);
      @(negedge clk);
      {hs_ack, hs_nak, hs_stall, hs_timeout} = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // point check between edges, after the stimulus settled
   task automatic pt(string tag, string what, int act, int exp);
      #1 cmp(tag, what, act, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      pt("R1", "rdata after reset", reg_rdata, 0);
      pt("R1", "tok_req after reset", tok_req, 0);
      rst_n = 1;
      idle(2);
      pt("R1", "rdata idle", reg_rdata, 8'h00);

      cur_req = "R2";
      wr(8'h01);
      pt("R2", "one packet queued", reg_rdata, 8'h02);
      wr(8'h01);
      pt("R2", "buffer full", reg_rdata, 8'h03);
      wr(8'h01);
      pt("R2", "commit when full ignored", reg_rdata, 8'h03);

      cur_req = "R4";
      hs(0);
      pt("R4", "ep_int after ack", ep_int, 1);
      pt("R4", "toggle after ack", tok_toggle, 1);
      hs(0);
      pt("R4", "empty after two acks", reg_rdata, 8'h00);
      pt("R3", "no request when empty", tok_req, 0);

      cur_req = "R5";
      wr(8'h01); hs(0);
      pt("R5", "toggle set", tok_toggle, 1);
      wr(8'h40);
      pt("R5", "clear toggle command", tok_toggle, 0);
      wr(8'h01); hs(0); wr(8'h11);
      pt("R5", "setup clears toggle", tok_toggle, 0);
      pt("R3", "setup token", tok_setup, 1);
      hs(0); wr(8'h00);
      pt("R3", "out token", tok_setup, 0);

      cur_req = "R6";
      wr(8'h01); wr(8'h01); wr(8'h08);
      pt("R6", "flush newest", reg_rdata, 8'h02);
      wr(8'h08);
      pt("R6", "second flush empties", reg_rdata, 8'h00);
      wr(8'h09);
      pt("R6", "flush with ready cancels", reg_rdata, 8'h00);

      cur_req = "R7";
      wr(8'h01); hs(3); hs(3);
      pt("R7", "two timeouts no error", reg_rdata, 8'h02);
      hs(3);
      pt("R7", "third timeout error", reg_rdata, 8'h04);
      cur_req = "R11";
      hs(0); hs(2);
      pt("R11", "handshake while empty", reg_rdata, 8'h04);
      cur_req = "R10";
      wr(8'h05);
      pt("R10", "writing 1 keeps error", reg_rdata, 8'h06);
      hs(0);
      pt("R11", "ack while halted", reg_rdata, 8'h06);
      wr(8'h02);
      pt("R10", "error cleared, fifo bit write ignored", reg_rdata, 8'h02);
      hs(0);

      cur_req = "R7";
      ep_type = 2'b00;
      wr(8'h01); repeat (4) hs(3);
      pt("R7", "control ignores timeouts", reg_rdata, 8'h02);
      ep_type = 2'b01; repeat (4) hs(3);
      pt("R7", "iso ignores timeouts", reg_rdata, 8'h02);
      ep_type = 2'b11; hs(3); hs(3); hs(0); wr(8'h01); hs(3); hs(3);
      pt("R7", "ack restarts retries", reg_rdata, 8'h02);
      hs(3);
      pt("R7", "interrupt type errors", reg_rdata, 8'h04);
      wr(8'h00);

      cur_req = "R9";
      ep_type = 2'b11; wr(8'h01); repeat (5) hs(1);
      pt("R9", "nak limit not for interrupt", reg_rdata, 8'h02);
      ep_type = 2'b10; hs(1); hs(1);
      pt("R9", "two naks", reg_rdata, 8'h02);
      hs(1);
      pt("R9", "nak timeout", reg_rdata, 8'h82);
      pt("R3", "halted no request", tok_req, 0);
      wr(8'h00);
      pt("R10", "nakto cleared", reg_rdata, 8'h02);
      hs(1); hs(1);
      pt("R10", "nak count restarted", reg_rdata, 8'h02);
      nak_limit = 0; repeat (6) hs(1);
      pt("R9", "limit zero disables", reg_rdata, 8'h02);
      nak_limit = 1; hs(1);
      pt("R9", "limit one", reg_rdata, 8'h82);
      wr(8'h00); hs(0); nak_limit = 3;

      cur_req = "R8";
      wr(8'h01); wr(8'h01); hs(2);
      pt("R8", "stall empties", reg_rdata, 8'h20);
      wr(8'h20);
      pt("R10", "stalled kept", reg_rdata, 8'h20);
      wr(8'h00);
      pt("R10", "stalled cleared", reg_rdata, 8'h00);
      idle(3);

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule